// File: doc/BRIEF.md
# Line-Compensated Fixed-Frequency PWM Generator

This block produces one pulse per switching period for a voltage-mode converter. All of its inputs are unsigned digital codes. An error code comes from the outer regulation loop. It is inverted and amplified by a fixed gain of 35/16 (about 2.2), then subtracted from a full-scale constant to form a control threshold. The result floors at zero. A digital ramp rises each cycle by a slope equal to the sampled line-voltage code. The pulse stays high while the ramp is at or below the threshold. A higher line voltage therefore gives a steeper ramp and a shorter pulse, with no help from the feedback loop.

Two clamps bound the on-time. The first is a fixed maximum duty of about 92% of the period. The second is a soft-start limit given in clock cycles, which an outside sequencer ramps up from zero. The period length can be set, so at a 250 MHz clock the switching frequency can be placed anywhere in the 200 to 600 kHz range. Each period opens with a one-cycle strobe. Every control input is captured only in that strobe cycle, so a pulse already running is never shortened or stretched by a new code.

Top module: `ffpwm_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after reset is released, `period_start` is 1 and `pwm_out` is 0.
- R2: `period_start` is high for one cycle out of every P cycles. P is max(`period_len`, PER_MIN) with PER_MIN = 16, and `period_len` is sampled in the strobe cycle.
- R3: `pwm_out` is low in the strobe cycle. In each period it forms at most one contiguous pulse, and that pulse begins in the cycle right after the strobe.
- R4: The control threshold is 512 − floor(err·35/16), floored at 0. Cycle k of the period (k = 1 … P−1) is on only if k·line ≤ threshold. An error code of 0 therefore gives the longest pulse, and a full-scale error code (255) gives no pulse at all.
- R5: The ramp slope is the line code. Doubling the line code roughly halves the ramp-limited pulse. A line code of 0 removes the ramp limit.
- R6: The pulse never lasts more than floor(P·236/256) cycles.
- R7: The pulse never lasts more than `ss_limit` cycles. A value of 0 suppresses the pulse.
- R8: Changes to `err_code`, `line_code`, `ss_limit` or `period_len` after the strobe cycle have no effect on the period in progress. They take effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_code | input | 8 | Error code from the regulation loop (inverting) |
| line_code | input | 8 | Sampled input-voltage code, used as the ramp slope |
| ss_limit | input | 12 | Soft-start on-time ceiling in cycles |
| period_len | input | 12 | Switching period in cycles |
| pwm_out | output | 1 | Per-period drive pulse |
| period_start | output | 1 | One-cycle strobe that opens each period |

## Verification
Three limits can end the pulse, and they can coincide: the ramp crossing the threshold, the duty cap and the soft-start ceiling. The directed cases pick codes so that each limit in turn is the tightest. For example, line 0 with error 0 leaves only the cap, and a soft-start of 10 undercuts both other limits. The measured pulse length is compared with the minimum of all three, computed independently. A further case changes every input right after a strobe. It checks that the running period keeps its old pulse and length, and that the next period shows the new values.

// File: rtl/ffpwm_gen.sv
module ffpwm_gen #(
  parameter int CW         = 8,
  parameter int PW         = 12,
  parameter int PER_MIN    = 16,
  parameter int CTL_FULL   = 512,
  parameter int DUTY_NUM   = 236,
  parameter int DUTY_SHIFT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] err_code,
  input  logic [CW-1:0] line_code,
  input  logic [PW-1:0] ss_limit,
  input  logic [PW-1:0] period_len,
  output logic          pwm_out,
  output logic          period_start
);
  localparam int RW  = PW + CW;
  localparam int GW  = CW + 6;
  localparam int CPW = PW + 9;

  logic [PW-1:0]  cnt, per_q, lim_q;
  logic [RW-1:0]  ramp, ctrl_q;
  logic [CW-1:0]  line_q;

  logic [GW-1:0]  gain_full;
  logic [RW-1:0]  gain, ctrl_nx;
  logic [PW-1:0]  per_eff, cap_cyc, lim_nx;
  logic [CPW-1:0] cap_full;

  assign gain_full = GW'(err_code) * GW'(35);
  assign gain      = RW'(gain_full >> 4);
  assign ctrl_nx   = (RW'(CTL_FULL) > gain) ? RW'(CTL_FULL) - gain : '0;

  assign per_eff   = (period_len < PW'(PER_MIN)) ? PW'(PER_MIN) : period_len;
  assign cap_full  = CPW'(per_eff) * CPW'(DUTY_NUM);
  assign cap_cyc   = PW'(cap_full >> DUTY_SHIFT);
  assign lim_nx    = (ss_limit < cap_cyc) ? ss_limit : cap_cyc;

  assign period_start = (cnt == '0);
  assign pwm_out      = !period_start && (cnt <= lim_q) && (ramp <= ctrl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= PW'(PER_MIN);
      lim_q  <= '0;
      ctrl_q <= '0;
      line_q <= '0;
      ramp   <= '0;
    end else if (period_start) begin
      cnt    <= PW'(1);
      per_q  <= per_eff;
      lim_q  <= lim_nx;
      ctrl_q <= ctrl_nx;
      line_q <= line_code;
      ramp   <= RW'(line_code);
    end else begin
      cnt  <= (cnt == per_q - PW'(1)) ? '0 : cnt + PW'(1);
      ramp <= ramp + RW'(line_q);
    end
  end

  assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  assert_strobe_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> !pwm_out);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(period_start));

  assert_hold_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> ($stable(ctrl_q) && $stable(lim_q) && $stable(line_q) && $stable(per_q)));
endmodule

// File: tb/ffpwm_gen_bench.sv
module ffpwm_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  err_code = '0;
  logic [7:0]  line_code = '0;
  logic [11:0] ss_limit = '0;
  logic [11:0] period_len = 12'd100;
  logic        pwm_out, period_start;

  int checks = 0;
  int fails  = 0;
  int meas_on, meas_per, meas_rises, meas_first;

  always #2 clk = ~clk;

  ffpwm_gen u_ffpwm_gen (
    .clk(clk), .rst_n(rst_n), .err_code(err_code), .line_code(line_code),
    .ss_limit(ss_limit), .period_len(period_len),
    .pwm_out(pwm_out), .period_start(period_start)
  );

  function automatic int exp_on(int per, int err, int line, int ss);
    int p, cap, g, ctl, n;
    p   = (per < 16) ? 16 : per;
    cap = (p * 236) / 256;
    g   = (err * 35) / 16;
    ctl = (g < 512) ? 512 - g : 0;
    n = 0;
    for (int k = 1; k < p; k++)
      if (k <= cap && k <= ss && k * line <= ctl) n++;
    return n;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure();
    logic prev;
    while (!period_start) @(negedge clk);
    meas_on = 0; meas_per = 1; meas_rises = 0; meas_first = -1; prev = 1'b0;
    checks++;
    if (pwm_out) begin fails++; $display("FAIL R3 pulse in strobe: actual 1 expected 0"); end
    forever begin
      @(negedge clk);
      if (period_start) break;
      if (pwm_out) begin
        meas_on++;
        if (!prev) begin meas_rises++; if (meas_first < 0) meas_first = meas_per; end
      end
      prev = pwm_out;
      meas_per++;
    end
  endtask

  task automatic run_case(string req, int per, int err, int line, int ss);
    int p;
    period_len = 12'(per); err_code = 8'(err); line_code = 8'(line); ss_limit = 12'(ss);
    p = (per < 16) ? 16 : per;
    measure();
    check(req, "pulse length", meas_on, exp_on(per, err, line, ss));
    check("R2", "period length", meas_per, p);
    if (meas_on > 0) begin
      check("R3", "pulse count", meas_rises, 1);
      check("R3", "pulse start offset", meas_first, 1);
    end
  endtask

  task automatic test_reset();
    #1;
    check("R1", "strobe in reset", int'(period_start), 1);
    check("R1", "pwm in reset", int'(pwm_out), 0);
    @(negedge clk); rst_n = 1'b1;
    check("R1", "strobe after release", int'(period_start), 1);
    check("R1", "pwm after release", int'(pwm_out), 0);
  endtask

  task automatic test_hold_R8();
    period_len = 12'd60; err_code = 8'd100; line_code = 8'd8; ss_limit = 12'd4095;
    while (!period_start) @(negedge clk);
    @(negedge clk);
    period_len = 12'd30; err_code = 8'd0; line_code = 8'd0; ss_limit = 12'd5;
    meas_on = int'(pwm_out); meas_per = 2;
    forever begin
      @(negedge clk);
      if (period_start) break;
      if (pwm_out) meas_on++;
      meas_per++;
    end
    check("R8", "old pulse kept", meas_on, exp_on(60, 100, 8, 4095));
    check("R8", "old period kept", meas_per, 60);
    measure();
    check("R8", "new pulse applied", meas_on, exp_on(30, 0, 0, 5));
    check("R8", "new period applied", meas_per, 30);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    run_case("R6", 100,   0,  4, 4095);
    run_case("R4", 100, 100,  8, 4095);
    run_case("R5", 100, 100, 16, 4095);
    run_case("R4", 100, 255, 16, 4095);
    run_case("R5", 100, 100,  0, 4095);
    run_case("R7", 100,   0,  4,   10);
    run_case("R7", 100,   0,  4,    0);
    run_case("R2",   5,   0,  0, 4095);
    run_case("R6",  40,   0,  0, 4095);
    run_case("R4", 200,  50,  3, 4095);
    test_hold_R8();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule